// File: doc/BRIEF.md
# Extended Register Indirect Access Sequencer

This block carries out one access to an extended (MMD) register of an Ethernet PHY. The PHY reaches those registers through the two-register indirect window of the Clause 22 management space. A request names a device number, a 16-bit target address, a two-bit access mode and, for writes, a 16-bit payload. The sequencer turns the request into four ordered Clause 22 transactions and presents them one at a time on a request/acknowledge management port. A separate serial MDIO master serves that port.

The window is made of a control register at Clause 22 address 0x0D and a data register at address 0x0E. The sequence is fixed. First the control register is written with the address function. Then the target address is written into the data register. Then the control register is written again with the chosen data function. Last, the payload is written to the data register, or for a read request the data register is read. A failed transaction ends the sequence at once. The result is reported with a one-cycle completion pulse, an error flag and, for reads, the value returned.

Top module: `mmd_indirect_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mgmt_req` are all low.
- R2: The first transaction is a write (`mgmt_we`=1) to register 0x0D with data bits [15:14]=00, bits [13:5]=0 and the device number in bits [4:0].
- R3: The second transaction is a write to register 0x0E carrying the request's 16-bit target address.
- R4: The third transaction is a write to register 0x0D carrying the mode in bits [15:14], zeros in [13:5] and the device number in [4:0]. Modes are 01 (no post-increment), 10 (post-increment on read and write) and 11 (post-increment on write only). A requested mode of 00 is sent as 01.
- R5: For a write request (`req_write`=1), the fourth transaction writes the payload to register 0x0E.
- R6: For a read request (`req_write`=0), the fourth transaction is a read (`mgmt_we`=0) of register 0x0E. The value on `mgmt_rdata` at its acknowledge appears on `rd_data` when `done` is high, and it stays there until the next successful read.
- R7: If an acknowledge arrives with `mgmt_err` high, no further transaction is issued. `done` then pulses with `err` high. A sequence that finishes cleanly ends with `err` low.
- R8: `req_valid` is accepted only while the block is idle. `busy` is high from the cycle after acceptance until the cycle before `done`, and `done` is high for exactly one cycle with `busy` low.
- R9: A request raised while the block is busy or finishing has no effect. It issues no transaction and does not alter the sequence in progress.
- R10: While `mgmt_req` is high and unacknowledged, `mgmt_reg`, `mgmt_we` and `mgmt_wdata` stay stable, and `mgmt_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_dev | input | 5 | Target device number |
| req_addr | input | 16 | Target extended register address |
| req_mode | input | 2 | Data function / post-increment mode |
| req_wdata | input | 16 | Payload for write access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion status, valid with done |
| rd_data | output | 16 | Value read by the last successful read |
| mgmt_req | output | 1 | Management transaction request |
| mgmt_we | output | 1 | 1 = write transaction, 0 = read |
| mgmt_reg | output | 5 | Clause 22 register address |
| mgmt_wdata | output | 16 | Write data for the transaction |
| mgmt_ack | input | 1 | Transaction complete |
| mgmt_err | input | 1 | Transaction failed, sampled with ack |
| mgmt_rdata | input | 16 | Read data, sampled with ack |

## Verification
The bench injects a failure at each of the four steps in turn. A design that did not stop would show a fifth or extra logged transaction, and one that dropped the status would complete with `err` low. Mode 00 is requested directly, and a design that forwarded it would write an address-function word in step three. Read requests with fresh random data on each acknowledge expose a design that captured `rd_data` from the wrong step or failed to hold it. A second request is also driven during every sequence, so a design that accepted it, or re-latched its fields, would alter the logged transactions.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int DEV_W  = 5;
  localparam int DATA_W = 16;
  localparam int REG_W  = 5;
  localparam int MODE_W = 2;
  localparam logic [REG_W-1:0] WIN_CTRL_REG = 5'h0D;
  localparam logic [REG_W-1:0] WIN_DATA_REG = 5'h0E;
  localparam logic [MODE_W-1:0] FN_ADDRESS = 2'b00;
  localparam logic [MODE_W-1:0] FN_NOINC   = 2'b01;

  typedef enum logic [1:0] {
    STEP_ADDR_FN  = 2'd0,
    STEP_ADDR_VAL = 2'd1,
    STEP_DATA_FN  = 2'd2,
    STEP_DATA_VAL = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  typedef struct packed {
    logic              wr;
    logic [DEV_W-1:0]  dev;
    logic [DATA_W-1:0] addr;
    logic [MODE_W-1:0] mode;
    logic [DATA_W-1:0] wdata;
  } acc_req_t;
endpackage

// File: rtl/mmd_req_hold.sv
module mmd_req_hold
  import mmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  acc_req_t          req_in,
  input  logic              cap_rd,
  input  logic [DATA_W-1:0] rd_in,
  output acc_req_t          req_q,
  output logic [DATA_W-1:0] rd_q
);
  acc_req_t          req_d;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    req_d = req_q;
    if (cap_req) req_d = req_in;
  end

  always_comb begin
    rd_d = rd_q;
    if (cap_rd) rd_d = rd_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      rd_q  <= '0;
    end else begin
      req_q <= req_d;
      rd_q  <= rd_d;
    end
  end
endmodule

// File: rtl/mmd_step_mux.sv
module mmd_step_mux
  import mmd_pkg::*;
(
  input  step_e             step,
  input  acc_req_t          req,
  output logic [REG_W-1:0]  reg_o,
  output logic              we_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PAD_W = DATA_W - MODE_W - DEV_W;

  logic [MODE_W-1:0] mode_eff;

  always_comb begin
    mode_eff = (req.mode == FN_ADDRESS) ? FN_NOINC : req.mode;
  end

  always_comb begin
    reg_o  = WIN_CTRL_REG;
    we_o   = 1'b1;
    data_o = '0;
    unique case (step)
      STEP_ADDR_FN: begin
        reg_o  = WIN_CTRL_REG;
        data_o = {FN_ADDRESS, {PAD_W{1'b0}}, req.dev};
      end
      STEP_ADDR_VAL: begin
        reg_o  = WIN_DATA_REG;
        data_o = req.addr;
      end
      STEP_DATA_FN: begin
        reg_o  = WIN_CTRL_REG;
        data_o = {mode_eff, {PAD_W{1'b0}}, req.dev};
      end
      STEP_DATA_VAL: begin
        reg_o  = WIN_DATA_REG;
        we_o   = req.wr;
        data_o = req.wdata;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mmd_seq_ctrl.sv
module mmd_seq_ctrl
  import mmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  ack,
  input  logic  ack_err,
  output logic  accept,
  output logic  last_ok,
  output step_e step,
  output logic  busy,
  output logic  done,
  output logic  err,
  output logic  xact_req
);
  state_e state_q, state_d;
  step_e  step_d;
  logic   err_d;
  logic   step_en;

  always_comb begin
    state_d = state_q;
    step_d  = step;
    err_d   = err;
    step_en = 1'b0;
    accept  = 1'b0;
    last_ok = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = ST_RUN;
          step_en = 1'b1;
          step_d  = STEP_ADDR_FN;
          err_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (ack) begin
          if (ack_err) begin
            state_d = ST_FIN;
            err_d   = 1'b1;
          end else if (step == STEP_DATA_VAL) begin
            state_d = ST_FIN;
            last_ok = 1'b1;
          end else begin
            step_en = 1'b1;
            step_d  = step_e'(step + 2'd1);
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step    <= STEP_ADDR_FN;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      err     <= err_d;
      if (step_en) step <= step_d;
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign xact_req = (state_q == ST_RUN);
  assign done     = (state_q == ST_FIN);
endmodule

// File: rtl/mmd_indirect_engine.sv
module mmd_indirect_engine
  import mmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [REG_W-1:0]  mgmt_reg,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic              mgmt_err,
  input  logic [DATA_W-1:0] mgmt_rdata
);
  acc_req_t req_in, req_q;
  step_e    step;
  logic     accept, last_ok, cap_rd;

  assign req_in = '{wr: req_write, dev: req_dev, addr: req_addr,
                    mode: req_mode, wdata: req_wdata};
  assign cap_rd = last_ok & ~req_q.wr;

  mmd_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (req_valid),
    .ack      (mgmt_ack),
    .ack_err  (mgmt_err),
    .accept   (accept),
    .last_ok  (last_ok),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .xact_req (mgmt_req)
  );

  mmd_req_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_req (accept),
    .req_in  (req_in),
    .cap_rd  (cap_rd),
    .rd_in   (mgmt_rdata),
    .req_q   (req_q),
    .rd_q    (rd_data)
  );

  mmd_step_mux u_mux (
    .step   (step),
    .req    (req_q),
    .reg_o  (mgmt_reg),
    .we_o   (mgmt_we),
    .data_o (mgmt_wdata)
  );
endmodule

// File: rtl/mmd_indirect_engine_chk.sv
module mmd_indirect_engine_chk
  import mmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mgmt_req,
  input logic              mgmt_we,
  input logic [REG_W-1:0]  mgmt_reg,
  input logic [DATA_W-1:0] mgmt_wdata,
  input logic              mgmt_ack,
  input logic              mgmt_err
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_reg)
                                 && $stable(mgmt_we) && $stable(mgmt_wdata)));

  assert_fail_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_ack && mgmt_err) |=> (done && err && !mgmt_req));

  assert_ctrl_is_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_reg == WIN_CTRL_REG) |-> mgmt_we);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mgmt_req);
endmodule

bind mmd_indirect_engine mmd_indirect_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .mgmt_req   (mgmt_req),
  .mgmt_we    (mgmt_we),
  .mgmt_reg   (mgmt_reg),
  .mgmt_wdata (mgmt_wdata),
  .mgmt_ack   (mgmt_ack),
  .mgmt_err   (mgmt_err)
);

// File: tb/mmd_indirect_engine_tb.sv
module mmd_indirect_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mode = '0;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic        mgmt_req, mgmt_we;
  logic [4:0]  mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic        mgmt_ack = 1'b0, mgmt_err = 1'b0;
  logic [15:0] mgmt_rdata = '0;

  int n_tests = 0, n_fail = 0;
  int log_n = 0;
  logic [4:0]  log_reg [0:15];
  logic        log_we  [0:15];
  logic [15:0] log_dat [0:15];
  int          fail_at = -1;
  int          wait_cnt = -1;
  logic [15:0] last_rd = '0;
  bit          finished = 0;

  always #4 clk = ~clk;

  mmd_indirect_engine u_dut (.*);

  // management slave model: acts on falling edges
  always @(negedge clk) begin
    if (mgmt_ack) begin
      mgmt_ack = 1'b0;
      mgmt_err = 1'b0;
      wait_cnt = -1;
    end else if (mgmt_req) begin
      if (wait_cnt < 0) wait_cnt = int'($urandom % 3);
      if (wait_cnt == 0) begin
        if (log_n < 16) begin
          log_reg[log_n] = mgmt_reg;
          log_we[log_n]  = mgmt_we;
          log_dat[log_n] = mgmt_wdata;
        end
        mgmt_err   = (log_n == fail_at);
        mgmt_rdata = 16'($urandom);
        last_rd    = mgmt_rdata;
        mgmt_ack   = 1'b1;
        log_n      = log_n + 1;
        wait_cnt   = -1;
      end else begin
        wait_cnt = wait_cnt - 1;
      end
    end
  end

  function automatic logic [15:0] ctrl_word(input logic [1:0] fn, input logic [4:0] dev);
    return {fn, 9'b0, dev};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [4:0] dev, input logic [15:0] addr,
                        input logic [1:0] mode, input logic [15:0] data, input int fstep);
    int waited;
    logic [1:0] mexp;
    int nexp;
    logic [15:0] rd_before;
    rd_before = rd_data;
    @(negedge clk);
    log_n = 0; fail_at = fstep;
    req_valid = 1; req_write = wr; req_dev = dev; req_addr = addr;
    req_mode = mode; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
    check(busy === 1'b1, "R8", "busy after accept", busy, 1);
    // R9: spurious request during the sequence
    @(negedge clk);
    req_valid = 1; req_write = ~wr; req_dev = ~dev; req_addr = ~addr;
    req_mode = ~mode; req_wdata = ~data;
    @(negedge clk);
    req_valid = 0;
    waited = 0;
    while (done !== 1'b1 && waited < 60) begin
      check(busy === 1'b1, "R8", "busy until done", busy, 1);
      @(negedge clk);
      waited++;
    end
    check(done === 1'b1, "R8", "done reached", done, 1);
    check(busy === 1'b0, "R8", "busy low with done", busy, 0);
    nexp = (fstep >= 0) ? fstep + 1 : 4;
    check(log_n == nexp, "R7", "transaction count", log_n, nexp);
    check(err === (fstep >= 0), "R7", "err flag", err, (fstep >= 0));
    if (nexp >= 1) begin
      check(log_reg[0] == 5'h0D && log_we[0] && log_dat[0] == ctrl_word(2'b00, dev),
            "R2", "step1", {log_reg[0], log_dat[0]}, {5'h0D, ctrl_word(2'b00, dev)});
    end
    if (nexp >= 2) begin
      check(log_reg[1] == 5'h0E && log_we[1] && log_dat[1] == addr,
            "R3", "step2", {log_reg[1], log_dat[1]}, {5'h0E, addr});
    end
    if (nexp >= 3) begin
      mexp = (mode == 2'b00) ? 2'b01 : mode;
      check(log_reg[2] == 5'h0D && log_we[2] && log_dat[2] == ctrl_word(mexp, dev),
            "R4", "step3", {log_reg[2], log_dat[2]}, {5'h0D, ctrl_word(mexp, dev)});
    end
    if (nexp >= 4) begin
      if (wr)
        check(log_reg[3] == 5'h0E && log_we[3] && log_dat[3] == data,
              "R5", "step4 write", {log_reg[3], log_dat[3]}, {5'h0E, data});
      else
        check(log_reg[3] == 5'h0E && !log_we[3],
              "R6", "step4 read", {log_reg[3], log_we[3]}, {5'h0E, 1'b0});
    end
    if (!wr && fstep < 0)
      check(rd_data == last_rd, "R6", "rd_data", rd_data, last_rd);
    else
      check(rd_data == rd_before, "R6", "rd_data held", rd_data, rd_before);
    @(negedge clk);
    check(done === 1'b0, "R8", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    check(log_n == nexp, "R9", "no extra transactions", log_n, nexp);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && err === 0 && mgmt_req === 0, "R1", "reset outputs",
          {busy, done, err, mgmt_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy === 0 && mgmt_req === 0, "R1", "idle after reset", {busy, mgmt_req}, 0);
    // directed corners
    run_op(1, 5'd7, 16'h003C, 2'b01, 16'h0000, -1);
    run_op(1, 5'd3, 16'h0014, 2'b00, 16'hBEEF, -1);
    run_op(0, 5'd31, 16'hFFFF, 2'b10, 16'h0, -1);
    run_op(0, 5'd1, 16'h1234, 2'b11, 16'h0, -1);
    for (int s = 0; s < 4; s++) run_op(s[0], 5'd9, 16'hA5A5, 2'b10, 16'h5A5A, s);
    // random mix
    for (int i = 0; i < 40; i++) begin
      int fs;
      fs = ($urandom % 5 == 0) ? int'($urandom % 4) : -1;
      run_op(1'($urandom), 5'($urandom), 16'($urandom), 2'($urandom), 16'($urandom), fs);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule